// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block reads one page from a large-page NAND flash device and passes the page contents downstream as a byte stream. A single-cycle start pulse supplies a 24-bit page number and a byte count. The sequencer then selects the device and waits for a fixed settling interval. It polls the device's ready line, writes the read-setup command, and writes five address cycles: two zero column bytes and three row bytes taken from the page number. It then writes the read-confirm command, waits for ready again, and issues one read strobe per byte.

The bytes leave through a valid/ready stream with a one-entry output register. A read strobe is only issued when that register is free or is being emptied in the same cycle, so a slow consumer pauses the device reads without losing data. Both ready waits are bounded. When a wait runs out, the sequence continues anyway and a timeout flag is reported alongside the completion pulse, so neither side of the block can hang. The byte count is normally the main area plus the spare area of the detected geometry (4314 for a 4 KiB page) and is sampled at each start.

Top module: `nand_page_reader`

## Requirements
- R1: The device bus carries exactly seven write cycles per operation, in this order: command 0x00 (flash_cmd_we high), address 0x00, address 0x00, address page[7:0], address page[15:8], address page[23:16] (flash_addr_we high), then command 0x30 (flash_cmd_we high).
- R2: flash_sel rises in the cycle after an accepted start. The first command strobe comes no earlier than PRE_DELAY+1 cycles after flash_sel rises, and exactly then when flash_rdy is already high.
- R3: While the device reports not ready, the sequencer issues no command, address or read strobe, unless the wait has timed out. No strobe is ever issued with flash_sel low.
- R4: After command 0x30 and a ready indication, exactly page_len read strobes are issued. Each byte sampled on flash_din appears once on m_data, in the order it was read.
- R5: While m_valid is high and m_ready is low, m_valid stays high and m_data stays unchanged. No byte is dropped or duplicated under any m_ready pattern.
- R6: Each ready wait ends after POLL_LIMIT consecutive not-ready cycles. The sequence then proceeds: after command 0x30 the first read strobe comes POLL_LIMIT+1 cycles after the command cycle. timed_out is high when done pulses, and all page_len bytes are still delivered.
- R7: done pulses for one cycle, in the cycle right after the final read strobe. flash_sel is low in that cycle.
- R8: A start pulse while busy is high has no effect: no extra bus cycles and no change of page.
- R9: timed_out is cleared by each accepted start, so a clean operation after a timed-out one reports timed_out low.
- R10: After reset, busy, done, flash_sel, all strobes and m_valid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| page_num | input | 24 | Page number, sampled at start |
| page_len | input | LEN_W | Bytes to read in the data phase, sampled at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | A ready wait expired during the current operation |
| flash_sel | output | 1 | Device select, active high |
| flash_cmd_we | output | 1 | Command write strobe |
| flash_addr_we | output | 1 | Address write strobe |
| flash_rd | output | 1 | Read strobe; flash_din sampled at the end of this cycle |
| flash_dout | output | 8 | Command or address byte |
| flash_din | input | 8 | Byte from the device |
| flash_rdy | input | 1 | Device ready |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Consumer accepts the byte |
| m_data | output | 8 | Output byte |

## Verification
The two functions that can fall in the same cycle are refilling the output register from a device read and the consumer draining it. A read strobe is allowed exactly when the held byte is being taken. These collisions are provoked by driving m_ready from a pseudo-random sequence during a long data phase. The stream is judged by comparing every accepted byte against the expected byte for its index, with no gap or repeat, and by checking that a stalled byte stays put. A second overlap is the deselect and done pulse coinciding with the final byte still waiting in the output register. This is judged by checking that done arrives one cycle after the last read strobe and that the waiting byte is still delivered afterwards.

// File: rtl/nprd_pkg.sv
package nprd_pkg;
  localparam int BYTE_W      = 8;
  localparam int ROW_BYTES   = 3;
  localparam int PAGE_W      = BYTE_W * ROW_BYTES;
  localparam int COL_BYTES   = 2;
  localparam int ADDR_CYCLES = COL_BYTES + ROW_BYTES;
  localparam int IDX_W       = $clog2(ADDR_CYCLES);

  localparam logic [BYTE_W-1:0] OP_READ_SETUP = 8'h00;
  localparam logic [BYTE_W-1:0] OP_READ_GO    = 8'h30;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_WAIT_A, ST_CMD_A, ST_ADDR,
    ST_CMD_B, ST_WAIT_B, ST_DATA, ST_FIN
  } seq_state_t;

  // Byte sent in address cycle idx: columns are zero, rows go low byte first.
  function automatic logic [BYTE_W-1:0] addr_byte(input logic [IDX_W-1:0] idx,
                                                  input logic [PAGE_W-1:0] page);
    int row;
    row = int'(idx) - COL_BYTES;
    if (row < 0) return '0;
    return page[row*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/nprd_interval.sv
module nprd_interval #(
  parameter int LIMIT = 4,
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);
  logic [CW-1:0] cnt;

  assign hit = en && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (en)     cnt <= hit ? '0 : cnt + 1'b1;
  end

  a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT - 1));
endmodule

// File: rtl/nprd_drain.sv
module nprd_drain #(
  parameter int LEN_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LEN_W-1:0]  len,
  input  logic              active,
  input  logic [BYTE_W-1:0] din,
  output logic              rd_stb,
  output logic              phase_end,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data
);
  logic [LEN_W-1:0] remaining;
  logic             slot_free;

  assign slot_free = !m_valid || m_ready;
  assign rd_stb    = active && (remaining != '0) && slot_free;
  assign phase_end = active && ((remaining == '0) ||
                                (rd_stb && remaining == LEN_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remaining <= '0;
    else if (load)   remaining <= len;
    else if (rd_stb) remaining <= remaining - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (rd_stb) begin
      m_valid <= 1'b1;
      m_data  <= din;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  a_r4_fill: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> m_valid);
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nprd_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int PRE_DELAY  = 4,
  parameter int POLL_LIMIT = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] page_num,
  input  logic [LEN_W-1:0]  page_len,
  output logic              busy,
  output logic              done,
  output logic              timed_out,
  output logic              flash_sel,
  output logic              flash_cmd_we,
  output logic              flash_addr_we,
  output logic              flash_rd,
  output logic [BYTE_W-1:0] flash_dout,
  input  logic [BYTE_W-1:0] flash_din,
  input  logic              flash_rdy,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data
);
  seq_state_t        state;
  logic [PAGE_W-1:0] page_q;
  logic [IDX_W-1:0]  idx;
  logic              to_q;

  // named internal events
  logic accept, in_pre, in_wait, poll_en, pre_hit, poll_hit, wait_exit;
  logic data_active, phase_end;

  assign accept      = (state == ST_IDLE) && start;
  assign in_pre      = (state == ST_PRE);
  assign in_wait     = (state == ST_WAIT_A) || (state == ST_WAIT_B);
  assign poll_en     = in_wait && !flash_rdy;
  assign wait_exit   = in_wait && (flash_rdy || poll_hit);
  assign data_active = (state == ST_DATA);

  nprd_interval #(.LIMIT(PRE_DELAY)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(!in_pre), .en(in_pre), .hit(pre_hit));

  nprd_interval #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(!in_wait), .en(poll_en), .hit(poll_hit));

  nprd_drain #(.LEN_W(LEN_W), .BYTE_W(BYTE_W)) u_drain (
    .clk(clk), .rst_n(rst_n), .load(accept), .len(page_len),
    .active(data_active), .din(flash_din), .rd_stb(flash_rd),
    .phase_end(phase_end), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      page_q <= '0;
      idx    <= '0;
      to_q   <= 1'b0;
    end else begin
      if (poll_en && poll_hit) to_q <= 1'b1;
      unique case (state)
        ST_IDLE: if (start) begin
          page_q <= page_num;
          to_q   <= 1'b0;
          state  <= ST_PRE;
        end
        ST_PRE:    if (pre_hit) state <= ST_WAIT_A;
        ST_WAIT_A: if (wait_exit) state <= ST_CMD_A;
        ST_CMD_A: begin
          idx   <= '0;
          state <= ST_ADDR;
        end
        ST_ADDR: begin
          idx <= idx + 1'b1;
          if (idx == IDX_W'(ADDR_CYCLES - 1)) state <= ST_CMD_B;
        end
        ST_CMD_B:  state <= ST_WAIT_B;
        ST_WAIT_B: if (wait_exit) state <= ST_DATA;
        ST_DATA:   if (phase_end) state <= ST_FIN;
        ST_FIN:    state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state != ST_IDLE);
  assign done          = (state == ST_FIN);
  assign timed_out     = to_q;
  assign flash_sel     = busy && (state != ST_FIN);
  assign flash_cmd_we  = (state == ST_CMD_A) || (state == ST_CMD_B);
  assign flash_addr_we = (state == ST_ADDR);

  always_comb begin
    unique case (state)
      ST_CMD_A: flash_dout = OP_READ_SETUP;
      ST_CMD_B: flash_dout = OP_READ_GO;
      ST_ADDR:  flash_dout = addr_byte(idx, page_q);
      default:  flash_dout = '0;
    endcase
  end

  a_r3_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_cmd_we || flash_addr_we || flash_rd) |-> flash_sel);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flash_cmd_we, flash_addr_we, flash_rd}));
  a_r2_select_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_sel) |-> $past(start && !busy));
  a_r7_done_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!flash_sel && !flash_rd));
  a_r6_timeout_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> $past(in_wait && !flash_rdy));
  a_r8_page_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(page_q));
endmodule

// File: tb/nand_page_reader_bench.sv
module nand_page_reader_bench;
  localparam int LEN_W = 16;
  localparam int PRE   = 3;
  localparam int POLL  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] page_num = '0;
  logic [15:0] page_len = '0;
  logic        busy, done, timed_out, flash_sel, flash_cmd_we, flash_addr_we, flash_rd;
  logic [7:0]  flash_dout, flash_din, m_data;
  logic        flash_rdy = 1'b1;
  logic        m_valid;
  logic        m_ready = 1'b1;

  always #5 clk = ~clk;

  nand_page_reader #(.LEN_W(LEN_W), .PRE_DELAY(PRE), .POLL_LIMIT(POLL)) u_nand_page_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .page_num(page_num), .page_len(page_len),
    .busy(busy), .done(done), .timed_out(timed_out), .flash_sel(flash_sel),
    .flash_cmd_we(flash_cmd_we), .flash_addr_we(flash_addr_we), .flash_rd(flash_rd),
    .flash_dout(flash_dout), .flash_din(flash_din), .flash_rdy(flash_rdy),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // device model and monitors
  logic [7:0] seed = 8'h00;
  int  rd_idx = 0;
  bit  rd_pend = 0;
  bit  stuck = 0;
  int  busy_left = 0, post_busy = 0;
  bit  bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int  cyc = 0;
  int  log_n, sel_before, cmd30_at, first_rd_at, last_rd_at, rd_n;
  int  done_n, done_at, done_to, done_sel, rx_n, rx_bad, hold_bad;
  int  sel_viol, rdy_viol;
  bit  first_cmd_seen, hold_prev;
  logic [7:0] hold_data;
  logic [8:0] log_ent [0:15];

  function automatic logic [7:0] dev_byte(input int k, input logic [7:0] s);
    return 8'((k * 7) + int'(s));
  endfunction

  assign flash_din = dev_byte(rd_idx, seed);

  always @(posedge clk) begin
    #1;
    if (rd_pend) begin rd_idx++; rd_pend = 0; end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready = bp_mode ? lfsr[3] : 1'b1;
  end

  always @(negedge clk) begin
    cyc++;
    if (!flash_rdy && !stuck) begin
      if (busy_left <= 1) flash_rdy = 1'b1; else busy_left--;
    end
    if ((flash_cmd_we || flash_addr_we || flash_rd) && !flash_sel) sel_viol++;
    if ((flash_cmd_we || flash_addr_we || flash_rd) && !flash_rdy && !stuck) rdy_viol++;
    if (flash_sel && !first_cmd_seen && !flash_cmd_we) sel_before++;
    if (flash_cmd_we || flash_addr_we) begin
      if (log_n < 16) log_ent[log_n] = {flash_cmd_we, flash_dout};
      log_n++;
      first_cmd_seen = 1;
    end
    if (flash_cmd_we && flash_dout == 8'h30) begin
      cmd30_at = cyc;
      flash_rdy = 1'b0;
      busy_left = post_busy;
    end
    if (flash_rd) begin
      if (rd_n == 0) first_rd_at = cyc;
      last_rd_at = cyc;
      rd_n++;
      rd_pend = 1;
    end
    if (done) begin
      done_n++; done_at = cyc; done_to = timed_out; done_sel = flash_sel;
    end
    if (hold_prev && !(m_valid && m_data == hold_data)) hold_bad++;
    hold_prev = m_valid && !m_ready;
    hold_data = m_data;
    if (m_valid && m_ready) begin
      if (m_data != dev_byte(rx_n, seed)) rx_bad++;
      rx_n++;
    end
  end

  task automatic clear_logs();
    log_n = 0; sel_before = 0; cmd30_at = -1; first_rd_at = -1; last_rd_at = -1;
    rd_n = 0; done_n = 0; done_at = -1; done_to = -1; done_sel = -1;
    rx_n = 0; rx_bad = 0; hold_bad = 0; sel_viol = 0; rdy_viol = 0;
    first_cmd_seen = 0; hold_prev = 0; rd_idx = 0;
  endtask

  // runs one operation; second start pulse injected when extra is set
  task automatic run_op(input logic [23:0] pg, input int len, input int pre_busy,
                        input int pb, input bit stk, input bit bp, input bit extra);
    @(posedge clk); #2;
    clear_logs();
    seed = pg[7:0] ^ 8'h5a;
    post_busy = pb; stuck = 0; bp_mode = bp;
    if (pre_busy > 0) begin flash_rdy = 1'b0; busy_left = pre_busy; end
    else flash_rdy = 1'b1;
    page_num = pg; page_len = 16'(len); start = 1'b1;
    @(posedge clk); #2; start = 1'b0;
    stuck = stk;
    if (extra) begin
      repeat (5) @(posedge clk);
      #2; page_num = ~pg; start = 1'b1;
      @(posedge clk); #2; start = 1'b0;
    end
    for (int i = 0; i < 20000 && done_n == 0; i++) @(posedge clk);
    stuck = 0;
    repeat (40) @(posedge clk);
    #2;
  endtask

  task automatic check_seq(input logic [23:0] pg, input string tag);
    logic [8:0] exp [0:6];
    exp[0] = {1'b1, 8'h00}; exp[1] = {1'b0, 8'h00}; exp[2] = {1'b0, 8'h00};
    exp[3] = {1'b0, pg[7:0]}; exp[4] = {1'b0, pg[15:8]}; exp[5] = {1'b0, pg[23:16]};
    exp[6] = {1'b1, 8'h30};
    chk(log_n == 7, {tag, " R1 bus cycle count"}, log_n, 7);
    for (int i = 0; i < 7; i++)
      chk(log_ent[i] === exp[i], {tag, " R1 bus cycle content"}, int'(log_ent[i]), int'(exp[i]));
  endtask

  task automatic check_data(input int len, input string tag);
    chk(rd_n == len, {tag, " R4 read strobes"}, rd_n, len);
    chk(rx_n == len, {tag, " R4 bytes delivered"}, rx_n, len);
    chk(rx_bad == 0, {tag, " R4 byte order/value"}, rx_bad, 0);
    chk(hold_bad == 0, {tag, " R5 stalled byte held"}, hold_bad, 0);
    chk(sel_viol == 0, {tag, " R3 strobe while deselected"}, sel_viol, 0);
    chk(done_n == 1, {tag, " R7 single done"}, done_n, 1);
    chk(done_at == last_rd_at + 1, {tag, " R7 done after last read"}, done_at, last_rd_at + 1);
    chk(done_sel == 0, {tag, " R7 deselected at done"}, done_sel, 0);
  endtask

  task automatic t_reset();
    #2;
    chk(busy == 0 && done == 0 && flash_sel == 0, "R10 idle outputs", {busy, done, flash_sel}, 0);
    chk({flash_cmd_we, flash_addr_we, flash_rd, m_valid} == 4'b0, "R10 strobes low",
        {flash_cmd_we, flash_addr_we, flash_rd, m_valid}, 0);
  endtask

  task automatic t_basic();
    run_op(24'h123456, 20, 0, 10, 0, 0, 0);
    check_seq(24'h123456, "basic");
    check_data(20, "basic");
    chk(sel_before == PRE + 1, "basic R2 settle cycles", sel_before, PRE + 1);
    chk(rdy_viol == 0, "basic R3 strobe while busy", rdy_viol, 0);
    chk(done_to == 0, "basic R6 no timeout", done_to, 0);
  endtask

  task automatic t_backpressure();
    run_op(24'hA5F00F, 37, 0, 6, 0, 1, 0);
    check_seq(24'hA5F00F, "bp");
    check_data(37, "bp");
  endtask

  task automatic t_prebusy();
    run_op(24'h00FF01, 9, 25, 4, 0, 0, 0);
    check_seq(24'h00FF01, "prebusy");
    check_data(9, "prebusy");
    chk(sel_before >= PRE + 1, "prebusy R2 settle cycles", sel_before, PRE + 1);
    chk(rdy_viol == 0, "prebusy R3 strobe while busy", rdy_viol, 0);
    chk(done_to == 0, "prebusy R9 flag cleared", done_to, 0);
  endtask

  task automatic t_timeout_and_ignore();
    run_op(24'h0ABCDE, 12, 0, 0, 1, 0, 1);
    check_seq(24'h0ABCDE, "timeout R8");
    check_data(12, "timeout");
    chk(first_rd_at - cmd30_at == POLL + 1, "R6 wait bound", first_rd_at - cmd30_at, POLL + 1);
    chk(done_to == 1, "R6 timeout reported", done_to, 1);
    chk(busy == 0, "R8 idle after run", busy, 0);
  endtask

  task automatic t_full();
    run_op(24'h7FFFFF, 4096 + 218, 0, 30, 0, 1, 0);
    check_seq(24'h7FFFFF, "full");
    check_data(4096 + 218, "full R4");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    #3 rst_n = 1'b1;
    t_basic();
    t_backpressure();
    t_timeout_and_ignore();
    t_prebusy();
    t_full();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R4 actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule